// File: doc/BRIEF.md
# Saturating Add/Subtract Unit

This unit is the signed saturating arithmetic slice of a processor execute stage. Each accepted request carries two register operands, a raw immediate field, an operation code and the current status word. One cycle later the unit returns the value to be written to the destination register, together with a new status word. The register file, decode and writeback logic sit outside the block.

Five operations are offered: addition of two registers, addition of a short sign-extended immediate to a register, register subtraction (second register minus first), subtraction of a long sign-extended immediate from the second register, and reverse register subtraction (first register minus second). When a signed overflow occurs, the result is clamped to the nearest representable limit. The zero and sign flags still describe the wrapped result. Overflow also sets a sticky saturation flag, which no operation ever clears.

Top module: `sat_addsub_unit`

## Requirements
- R1: A request is captured on a clock edge where `in_valid` is 1. `out_valid` is 1 in the cycle after that edge and 0 after an edge without a request. While `out_valid` is 0, `out_result` and `out_psw` hold their last values. A synchronous reset clears `out_valid`, `out_result` and `out_psw` to 0.
- R2: Op code 0 (register add) produces `in_rs1 + in_rs2`, wrapping modulo 2^32, when no signed overflow occurs.
- R3: For additions, signed overflow occurs when both addends have the same sign and the wrapped sum has the other sign. The result is then 0x80000000 if the first addend is negative, and 0x7FFFFFFF otherwise. The first addend is `in_rs1` for op 0 and the immediate for op 1.
- R4: Op code 1 adds `in_imm[4:0]`, sign-extended to 32 bits, to `in_rs2`. Immediate bits 15:5 have no effect.
- R5: Op code 2 computes `in_rs2 - in_rs1`. For every subtraction, signed overflow occurs when the minuend and subtrahend signs differ and the wrapped difference's sign differs from the minuend's. The result then clamps to 0x80000000 for a negative minuend and to 0x7FFFFFFF otherwise.
- R6: Op code 3 computes `in_rs2` minus `in_imm[15:0]` sign-extended to 32 bits.
- R7: Op code 4 computes `in_rs1 - in_rs2`, with `in_rs1` as the minuend.
- R8: The zero flag (status bit 0) and sign flag (status bit 1) are taken from the wrapped result, even when the output is clamped.
- R9: The carry flag (status bit 3) is the unsigned carry out of bit 31 for additions. For subtractions it is set when the minuend is below the subtrahend as unsigned values.
- R10: The overflow flag (status bit 2) reports signed overflow. The saturation flag (status bit 4) is the OR of its input value and the overflow, so an operation never clears it.
- R11: Status bits 0 to 3 are rewritten by every operation with codes 0 to 4. All status bits from 5 upward pass from `in_psw` to `out_psw` unchanged.
- R12: Op codes 5, 6 and 7 return `in_rs2` as the result and `in_psw` unchanged as the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code (0 add reg, 1 add short imm, 2 sub reg, 3 sub long imm, 4 reverse sub) |
| in_rs1 | input | 32 | First register operand |
| in_rs2 | input | 32 | Second register operand (destination's old value) |
| in_imm | input | 16 | Raw immediate field |
| in_psw | input | 32 | Current status word |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 32 | Value for the destination register |
| out_psw | output | 32 | Updated status word |

## Verification
The bench builds the unit with its defaults: a 32-bit data path, a 32-bit status word, a 16-bit long immediate and a 5-bit short immediate. At these widths, directed cases can reach both clamp limits exactly from register and immediate operands. The same widths make the upper-immediate bits that must be ignored, and the status bits above the flag field, visible at the ports. A seeded random sweep then compares every operation code, including the unused ones, against an arithmetic model that uses wide signed integers.

// File: rtl/sat_pkg.sv
package sat_pkg;

    typedef enum logic [2:0] {
        OP_ADD_RR = 3'd0,
        OP_ADD_SI = 3'd1,
        OP_SUB_RR = 3'd2,
        OP_SUB_LI = 3'd3,
        OP_RSB_RR = 3'd4
    } sat_op_e;

    // Flag positions inside the status word
    localparam int FLG_Z   = 0;
    localparam int FLG_S   = 1;
    localparam int FLG_OV  = 2;
    localparam int FLG_CY  = 3;
    localparam int FLG_SAT = 4;
    localparam int FLG_CNT = 5;

endpackage

// File: rtl/sat_operand_sel.sv
module sat_operand_sel #(
    parameter int DATA_W      = 32,
    parameter int LONG_IMM_W  = 16,
    parameter int SHORT_IMM_W = 5
) (
    input  logic [2:0]            op,
    input  logic [DATA_W-1:0]     rs1,
    input  logic [DATA_W-1:0]     rs2,
    input  logic [LONG_IMM_W-1:0] imm,
    output logic [DATA_W-1:0]     opnd_x,
    output logic [DATA_W-1:0]     opnd_y,
    output logic                  is_sub,
    output logic                  known
);
    import sat_pkg::*;

    localparam int SHORT_PAD = DATA_W - SHORT_IMM_W;
    localparam int LONG_PAD  = DATA_W - LONG_IMM_W;

    logic [DATA_W-1:0] imm_short_ext;
    logic [DATA_W-1:0] imm_long_ext;

    generate
        if (LONG_PAD > 0) begin : g_long_pad
            assign imm_long_ext = {{LONG_PAD{imm[LONG_IMM_W-1]}}, imm};
        end else begin : g_long_trunc
            assign imm_long_ext = imm[DATA_W-1:0];
        end
    endgenerate

    assign imm_short_ext = {{SHORT_PAD{imm[SHORT_IMM_W-1]}}, imm[SHORT_IMM_W-1:0]};

    // opnd_x: first addend or minuend (drives clamp direction)
    // opnd_y: second addend or subtrahend
    always_comb begin
        opnd_x = rs2;
        opnd_y = '0;
        is_sub = 1'b0;
        known  = 1'b1;
        case (op)
            OP_ADD_RR: begin
                opnd_x = rs1;
                opnd_y = rs2;
            end
            OP_ADD_SI: begin
                opnd_x = imm_short_ext;
                opnd_y = rs2;
            end
            OP_SUB_RR: begin
                opnd_x = rs2;
                opnd_y = rs1;
                is_sub = 1'b1;
            end
            OP_SUB_LI: begin
                opnd_x = rs2;
                opnd_y = imm_long_ext;
                is_sub = 1'b1;
            end
            OP_RSB_RR: begin
                opnd_x = rs1;
                opnd_y = rs2;
                is_sub = 1'b1;
            end
            default: begin
                known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sat_core.sv
module sat_core #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opnd_x,
    input  logic [DATA_W-1:0] opnd_y,
    input  logic              is_sub,
    output logic [DATA_W-1:0] raw,
    output logic              carry,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide;

    always_comb begin
        if (is_sub) begin
            wide = {1'b0, opnd_x} - {1'b0, opnd_y};
        end else begin
            wide = {1'b0, opnd_x} + {1'b0, opnd_y};
        end
        raw   = wide[MSB:0];
        // top bit is carry out for add, borrow for subtract
        carry = wide[DATA_W];
        if (is_sub) begin
            ovf = (opnd_x[MSB] != opnd_y[MSB]) && (raw[MSB] != opnd_x[MSB]);
        end else begin
            ovf = (opnd_x[MSB] == opnd_y[MSB]) && (raw[MSB] != opnd_x[MSB]);
        end
    end

endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              ovf,
    input  logic              neg_side,
    output logic [DATA_W-1:0] clamped
);
    localparam logic [DATA_W-1:0] LIM_MIN = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] LIM_MAX = {1'b0, {(DATA_W-1){1'b1}}};

    always_comb begin
        if (!ovf) begin
            clamped = raw;
        end else if (neg_side) begin
            clamped = LIM_MIN;
        end else begin
            clamped = LIM_MAX;
        end
    end

endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit #(
    parameter int DATA_W      = 32,
    parameter int PSW_W       = 32,
    parameter int LONG_IMM_W  = 16,
    parameter int SHORT_IMM_W = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [2:0]            in_op,
    input  logic [DATA_W-1:0]     in_rs1,
    input  logic [DATA_W-1:0]     in_rs2,
    input  logic [LONG_IMM_W-1:0] in_imm,
    input  logic [PSW_W-1:0]      in_psw,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     out_result,
    output logic [PSW_W-1:0]      out_psw
);
    import sat_pkg::*;

    localparam int MSB = DATA_W - 1;
    localparam logic [PSW_W-1:0] FLAG_MASK = PSW_W'((1 << FLG_CNT) - 1);
    localparam logic [DATA_W-1:0] LIM_MIN  = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] LIM_MAX  = {1'b0, {(DATA_W-1){1'b1}}};

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic [PSW_W-1:0]  psw;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [DATA_W-1:0] opnd_x, opnd_y, raw, clamped;
    logic              is_sub, known, carry, ovf;

    sat_operand_sel #(
        .DATA_W      (DATA_W),
        .LONG_IMM_W  (LONG_IMM_W),
        .SHORT_IMM_W (SHORT_IMM_W)
    ) u_sel (
        .op     (in_op),
        .rs1    (in_rs1),
        .rs2    (in_rs2),
        .imm    (in_imm),
        .opnd_x (opnd_x),
        .opnd_y (opnd_y),
        .is_sub (is_sub),
        .known  (known)
    );

    sat_core #(.DATA_W(DATA_W)) u_core (
        .opnd_x (opnd_x),
        .opnd_y (opnd_y),
        .is_sub (is_sub),
        .raw    (raw),
        .carry  (carry),
        .ovf    (ovf)
    );

    sat_clamp #(.DATA_W(DATA_W)) u_clamp (
        .raw      (raw),
        .ovf      (ovf),
        .neg_side (opnd_x[MSB]),
        .clamped  (clamped)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.psw = in_psw;
            if (known) begin
                stage_d.res          = clamped;
                stage_d.psw[FLG_Z]   = (raw == '0);
                stage_d.psw[FLG_S]   = raw[MSB];
                stage_d.psw[FLG_OV]  = ovf;
                stage_d.psw[FLG_CY]  = carry;
                stage_d.psw[FLG_SAT] = in_psw[FLG_SAT] | ovf;
            end else begin
                stage_d.res = in_rs2;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid  = stage_q.vld;
    assign out_result = stage_q.res;
    assign out_psw    = stage_q.psw;

    // R1: one-cycle valid timing and hold while idle
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r1_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_psw)));

    // R3: an overflowing known operation lands on a limit value
    a_r3_clamp_limit: assert property (@(posedge clk) disable iff (rst)
        (in_valid && known && ovf) |=> (out_result == LIM_MIN || out_result == LIM_MAX));

    // R10: saturation flag never cleared by an operation
    a_r10_sat_sticky: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_psw[FLG_SAT]) |=> out_psw[FLG_SAT]);

    // R11: bits outside the flag field pass through
    a_r11_passthru: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((out_psw & ~FLAG_MASK) == $past(in_psw & ~FLAG_MASK)));

    // R12: unused codes leave operand and status untouched
    a_r12_unused_code: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !known) |=> (out_result == $past(in_rs2) && out_psw == $past(in_psw)));

endmodule

// File: tb/sat_addsub_unit_tb.sv
module sat_addsub_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  in_op;
    logic [31:0] in_rs1, in_rs2, in_psw;
    logic [15:0] in_imm;
    logic        out_valid;
    logic [31:0] out_result, out_psw;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sat_addsub_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_rs1     (in_rs1),
        .in_rs2     (in_rs2),
        .in_imm     (in_imm),
        .in_psw     (in_psw),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_psw    (out_psw)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Drive one request; returns after the result register is loaded
    task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, input logic [31:0] psw);
        @(negedge clk);
        in_op    = op;
        in_rs1   = a;
        in_rs2   = b;
        in_imm   = imm;
        in_psw   = psw;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic [31:0] res, input logic [31:0] psw);
        chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        chk({tag, " result"}, out_result, res);
        chk({tag, " psw"}, out_psw, psw);
    endtask

    // Arithmetic model in wide signed integers, built from the requirements
    task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, input logic [31:0] psw_in,
                         output logic [31:0] r, output logic [31:0] p);
        logic [31:0] x, y;
        logic [32:0] w;
        bit          sub;
        bit          ov;
        longint      s;
        sub = 1'b0;
        x   = a;
        y   = b;
        case (op)
            3'd0: begin x = a; y = b; end
            3'd1: begin x = {{27{imm[4]}}, imm[4:0]}; y = b; end
            3'd2: begin x = b; y = a; sub = 1'b1; end
            3'd3: begin x = b; y = {{16{imm[15]}}, imm}; sub = 1'b1; end
            3'd4: begin x = a; y = b; sub = 1'b1; end
            default: begin
                r = b;
                p = psw_in;
                return;
            end
        endcase
        if (sub) s = longint'($signed(x)) - longint'($signed(y));
        else     s = longint'($signed(x)) + longint'($signed(y));
        ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        if (sub) w = {1'b0, x} - {1'b0, y};
        else     w = {1'b0, x} + {1'b0, y};
        r = ov ? (x[31] ? 32'h8000_0000 : 32'h7FFF_FFFF) : w[31:0];
        p    = psw_in & ~32'h1F;
        p[0] = (w[31:0] == 32'd0);
        p[1] = w[31];
        p[2] = ov;
        p[3] = w[32];
        p[4] = psw_in[4] | ov;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R1 reset result", out_result, 32'd0);
        chk("R1 reset psw", out_psw, 32'd0);
    endtask

    task automatic t_add_reg();
        issue(3'd0, 32'd5, 32'd7, 16'h0, 32'hFFFF_FF00);
        expect_out("R2 R11 add plain", 32'd12, 32'hFFFF_FF00);
        issue(3'd0, 32'hFFFF_FFFF, 32'd1, 16'h0, 32'h0);
        expect_out("R9 add carry to zero", 32'd0, 32'h0000_0009);
    endtask

    task automatic t_add_overflow();
        issue(3'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 32'h0);
        expect_out("R3 R8 add pos clamp", 32'h7FFF_FFFF, 32'h0000_0016);
        issue(3'd0, 32'h8000_0000, 32'h8000_0000, 16'h0, 32'h0);
        expect_out("R3 R8 add neg clamp zero flag", 32'h8000_0000, 32'h0000_001D);
    endtask

    task automatic t_add_imm5();
        issue(3'd1, 32'hDEAD_0000, 32'd10, 16'hABDF, 32'h0);
        expect_out("R4 imm5 minus one upper ignored", 32'd9, 32'h0000_0008);
        issue(3'd1, 32'h0, 32'd1, 16'hFFEF, 32'h0);
        expect_out("R4 imm5 plus fifteen", 32'd16, 32'h0);
        issue(3'd1, 32'h0, 32'h8000_0000, 16'h001F, 32'h0);
        expect_out("R3 R4 imm5 neg clamp", 32'h8000_0000, 32'h0000_001C);
    endtask

    task automatic t_sub_reg();
        issue(3'd2, 32'd5, 32'd3, 16'h0, 32'h0);
        expect_out("R5 R9 sub borrow", 32'hFFFF_FFFE, 32'h0000_000A);
        issue(3'd2, 32'd1, 32'h8000_0000, 16'h0, 32'h0);
        expect_out("R5 sub neg clamp", 32'h8000_0000, 32'h0000_0014);
        issue(3'd2, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 16'h0, 32'h0);
        expect_out("R5 R8 sub pos clamp", 32'h7FFF_FFFF, 32'h0000_001E);
    endtask

    task automatic t_sub_imm();
        issue(3'd3, 32'h0, 32'd100, 16'hFF9C, 32'h0);
        expect_out("R6 R9 subimm negative imm", 32'd200, 32'h0000_0008);
        issue(3'd3, 32'h0, 32'h0000_1234, 16'h1234, 32'h0);
        expect_out("R6 R8 subimm zero", 32'd0, 32'h0000_0001);
    endtask

    task automatic t_rsub();
        issue(3'd4, 32'd10, 32'd3, 16'h0, 32'h0);
        expect_out("R7 rsub plain", 32'd7, 32'h0);
        issue(3'd4, 32'h8000_0000, 32'd1, 16'h0, 32'h0);
        expect_out("R7 rsub neg clamp", 32'h8000_0000, 32'h0000_0014);
    endtask

    task automatic t_flags();
        issue(3'd0, 32'd1, 32'd1, 16'h0, 32'h0000_0010);
        expect_out("R10 sat stays set", 32'd2, 32'h0000_0010);
        issue(3'd0, 32'd1, 32'd1, 16'h0, 32'h0000_000F);
        expect_out("R11 stale flags cleared", 32'd2, 32'h0);
    endtask

    task automatic t_unused();
        issue(3'd5, 32'h1111_1111, 32'h0000_CAFE, 16'h7777, 32'hDEAD_BEEF);
        expect_out("R12 code five", 32'h0000_CAFE, 32'hDEAD_BEEF);
        issue(3'd7, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'h0, 32'h0);
        expect_out("R12 code seven", 32'h7FFF_FFFF, 32'h0);
    endtask

    task automatic t_hold();
        issue(3'd0, 32'd40, 32'd2, 16'h0, 32'h0);
        @(negedge clk);
        in_op  = 3'd2;
        in_rs1 = 32'h1234_5678;
        in_rs2 = 32'h8765_4321;
        in_psw = 32'hFFFF_FFFF;
        @(negedge clk);
        chk("R1 idle valid low", {31'd0, out_valid}, 32'd0);
        chk("R1 idle result held", out_result, 32'd42);
        chk("R1 idle psw held", out_psw, 32'h0);
    endtask

    task automatic t_random();
        logic [31:0] er, ep, a, b, p;
        logic [15:0] im;
        logic [2:0]  op;
        for (int i = 0; i < 400; i++) begin
            op = 3'($urandom_range(0, 7));
            a  = $urandom;
            b  = $urandom;
            im = 16'($urandom);
            p  = $urandom;
            if (i % 4 == 0) a = {a[31], 31'h7FFF_FFF0} | (a & 32'hF);
            model(op, a, b, im, p, er, ep);
            issue(op, a, b, im, p);
            expect_out("R2 R3 R5 R6 R7 R9 R10 random", er, ep);
        end
    endtask

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        in_op    = 3'd0;
        in_rs1   = '0;
        in_rs2   = '0;
        in_imm   = '0;
        in_psw   = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_add_reg();
        t_add_overflow();
        t_add_imm5();
        t_sub_reg();
        t_sub_imm();
        t_rsub();
        t_flags();
        t_unused();
        t_hold();
        t_random();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule